// File: doc/BRIEF.md
# Serial Unlock Sequence Gate

This block guards a hidden register window behind a fixed 64-bit key. It watches a one-bit write stream, qualified by a per-bit strobe and an active-low chip enable. The window opens only when all 64 bits arrive in the exact key order. The window then stays open for one 64-bit data transfer and closes by itself.

A power-good flag acts as a digital power-fail guard. While power is bad:
- In RAM mode, the downstream chip enable is forced inactive.
- Any open window is cancelled and a one-cycle abort pulse is raised.
- Every bit strobe is refused until power returns.

The control is a three-state machine:
- **HUNT**: compares incoming bits against the key.
- **OPEN**: the unlocked data window.
- **FAIL**: power is bad.

Its transitions are:
- HUNT→OPEN on the 64th matching bit.
- OPEN→HUNT after 64 window strobes, or when chip enable is released.
- Any state→FAIL whenever power-good is low.
- FAIL→HUNT on the first cycle that power is good again.

Inside HUNT, a mismatch or a released chip enable clears the bit position back to byte 0.

Top module: `unlock_seq_gate`

## Requirements
- R1: The key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C, sent byte 0 first, each byte least-significant bit first. The bit is sampled on a clock edge where `ser_stb`=1, `ce_in_n`=0 and `pwr_good`=1. When all 64 bits match, `unlocked` is 1 from the next clock edge.
- R2: `unlocked` stays 0 after only 63 matching bits; it rises only with the 64th.
- R3: A mismatching bit throws away all progress. Matching restarts at key bit 0 of byte 0, so a key that is completed after a mismatch does not unlock.
- R4: With `ce_in_n`=1, strobes are ignored and the bit position clears. Raising `ce_in_n` while unlocked closes the window at the next edge.
- R5: The window accepts exactly 64 strobes. `unlocked` is still 1 after 63 of them and returns to 0 after the 64th.
- R6: In RAM mode (`mode_rom`=0) with `pwr_good`=1, `ce_out_n` equals `ce_in_n` with no clock delay.
- R7: In RAM mode with `pwr_good`=0, `ce_out_n` is 1 whatever `ce_in_n` is.
- R8: In ROM mode (`mode_rom`=1), `ce_out_n` equals `ce_in_n` even while `pwr_good`=0.
- R9: `abort_pulse` is high for exactly one cycle when `pwr_good` is low while the block is unlocked. It stays low when power drops while locked.
- R10: `pwr_good`=0 closes the window and clears the bit position. Strobes are ignored until `pwr_good` returns, after which a full key unlocks again.
- R11: After reset, `unlocked`=0, `abort_pulse`=0, and the bit position is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Serial data bit |
| ser_stb | input | 1 | Bit strobe, one per serial bit |
| ce_in_n | input | 1 | Active-low chip enable from the host |
| pwr_good | input | 1 | High while supply is above the fail threshold |
| mode_rom | input | 1 | 0 = RAM mode, 1 = ROM mode |
| ce_out_n | output | 1 | Gated active-low chip enable to memory |
| unlocked | output | 1 | High while the hidden window is open |
| abort_pulse | output | 1 | One-cycle pulse when an open window is cancelled by power fail |

## Verification
The bench flips single key bits at the first bit, a middle bit and the last bit. It also sends the bytes in reversed order and a key with a mismatch at bit 40 followed by the remaining tail. A matcher that unlocks one bit early, keeps progress after a mismatch, or takes bits MSB first would open on one of these streams or fail to open on the true key.

The window is counted to 63 and then 64 strobes. An off-by-one counter would close it early or leave it open.

Power is dropped both while open and while hunting, and a full key is sent during the fail. A guard that forgot to gate `ce_out_n`, pulsed abort while locked, or accepted strobes during a fail shows up at the ports.

// File: rtl/ulk_pkg.sv
`timescale 1ns/1ps
package ulk_pkg;

    localparam int KEY_BYTES = 8;
    localparam int KEY_BITS  = KEY_BYTES * 8;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_OPEN = 2'd1,
        ST_FAIL = 2'd2
    } ulk_state_e;

    // Key bytes repeat with a period of four.
    function automatic logic [7:0] key_byte(input int idx);
        logic [7:0] val;
        case (idx % 4)
            0:       val = 8'hC5;
            1:       val = 8'h3A;
            2:       val = 8'hA3;
            default: val = 8'h5C;
        endcase
        return val;
    endfunction

endpackage

// File: rtl/ulk_key_rom.sv
`timescale 1ns/1ps
module ulk_key_rom #(
    parameter int NBYTES = ulk_pkg::KEY_BYTES,
    localparam int NBITS = NBYTES * 8,
    localparam int IDX_W = $clog2(NBITS)
) (
    input  logic [IDX_W-1:0] idx,
    output logic             key_bit
);

    logic [NBITS-1:0] key_vec;

    // Byte b occupies serial positions 8*b .. 8*b+7, LSB first.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign key_vec[8*b +: 8] = ulk_pkg::key_byte(b);
    end

    assign key_bit = key_vec[idx];

endmodule

// File: rtl/ulk_bit_counter.sv
`timescale 1ns/1ps
module ulk_bit_counter #(
    parameter int LIMIT = ulk_pkg::KEY_BITS,
    localparam int CW   = $clog2(LIMIT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          at_last
);

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    assign at_last = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= at_last ? '0 : cnt + CW'(1);
        end
    end

    // R3 / R10: a clear request empties the position.
    p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

    // R5: the last position wraps back to zero.
    p_wrap_at_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && at_last && !clear) |=> (cnt == '0));

endmodule

// File: rtl/ulk_ce_guard.sv
`timescale 1ns/1ps
module ulk_ce_guard (
    input  logic ce_in_n,
    input  logic pwr_good,
    input  logic mode_rom,
    output logic ce_out_n
);

    logic protect;

    // Write protection applies only in RAM mode.
    assign protect  = !mode_rom && !pwr_good;
    assign ce_out_n = protect ? 1'b1 : ce_in_n;

endmodule

// File: rtl/ulk_ctrl_fsm.sv
`timescale 1ns/1ps
module ulk_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_bit,
    input  logic ser_stb,
    input  logic ce_in_n,
    input  logic pwr_good,
    input  logic key_bit,
    input  logic at_last,
    output logic cnt_clear,
    output logic cnt_inc,
    output logic unlocked,
    output logic abort_pulse
);
    import ulk_pkg::*;

    ulk_state_e state_q, state_d;

    // Next state and counter control.
    always_comb begin
        state_d   = state_q;
        cnt_clear = 1'b0;
        cnt_inc   = 1'b0;
        if (!pwr_good) begin
            state_d   = ST_FAIL;
            cnt_clear = 1'b1;
        end else begin
            unique case (state_q)
                ST_FAIL: begin
                    state_d   = ST_HUNT;
                    cnt_clear = 1'b1;
                end
                ST_HUNT: begin
                    if (ce_in_n) begin
                        cnt_clear = 1'b1;
                    end else if (ser_stb) begin
                        if (ser_bit == key_bit) begin
                            cnt_inc = 1'b1;
                            if (at_last) state_d = ST_OPEN;
                        end else begin
                            cnt_clear = 1'b1;
                        end
                    end
                end
                ST_OPEN: begin
                    if (ce_in_n) begin
                        cnt_clear = 1'b1;
                        state_d   = ST_HUNT;
                    end else if (ser_stb) begin
                        cnt_inc = 1'b1;
                        if (at_last) state_d = ST_HUNT;
                    end
                end
                default: begin
                    state_d   = ST_HUNT;
                    cnt_clear = 1'b1;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked    <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            unlocked    <= (state_d == ST_OPEN);
            abort_pulse <= (state_q == ST_OPEN) && !pwr_good;
        end
    end

    // R2: the window opens only on a matching final key bit.
    p_unlock_full_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(at_last) && $past(ser_stb) && ($past(ser_bit) == $past(key_bit))));

    // R4: a released chip enable leaves the block locked.
    p_ce_release_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ce_in_n |=> !unlocked);

    // R10: power fail leaves the block locked.
    p_fail_locks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !unlocked);

    // R9: abort is a single-cycle pulse.
    p_abort_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);

    // R9: abort only follows a power drop during an open window.
    p_abort_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> ($past(unlocked) && !$past(pwr_good)));

endmodule

// File: rtl/unlock_seq_gate.sv
`timescale 1ns/1ps
module unlock_seq_gate #(
    parameter int KEY_BYTES = ulk_pkg::KEY_BYTES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_bit,
    input  logic ser_stb,
    input  logic ce_in_n,
    input  logic pwr_good,
    input  logic mode_rom,
    output logic ce_out_n,
    output logic unlocked,
    output logic abort_pulse
);

    localparam int KEY_BITS = KEY_BYTES * 8;
    localparam int CNT_W    = $clog2(KEY_BITS);

    logic [CNT_W-1:0] bit_pos;
    logic             at_last;
    logic             key_bit;
    logic             cnt_clear;
    logic             cnt_inc;

    ulk_ce_guard u_guard (
        .ce_in_n  (ce_in_n),
        .pwr_good (pwr_good),
        .mode_rom (mode_rom),
        .ce_out_n (ce_out_n)
    );

    ulk_key_rom #(.NBYTES(KEY_BYTES)) u_rom (
        .idx     (bit_pos),
        .key_bit (key_bit)
    );

    ulk_bit_counter #(.LIMIT(KEY_BITS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .inc     (cnt_inc),
        .cnt     (bit_pos),
        .at_last (at_last)
    );

    ulk_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_bit     (ser_bit),
        .ser_stb     (ser_stb),
        .ce_in_n     (ce_in_n),
        .pwr_good    (pwr_good),
        .key_bit     (key_bit),
        .at_last     (at_last),
        .cnt_clear   (cnt_clear),
        .cnt_inc     (cnt_inc),
        .unlocked    (unlocked),
        .abort_pulse (abort_pulse)
    );

    // R7: in RAM mode a supply drop blocks the memory enable at once.
    p_fail_blocks_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_rom && $fell(pwr_good)) |-> ce_out_n);

    // R8: in ROM mode a supply drop leaves the enable untouched.
    p_rom_passes_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rom && $fell(pwr_good)) |-> (ce_out_n == ce_in_n));

endmodule

// File: tb/unlock_seq_gate_test.sv
`timescale 1ns/1ps
module unlock_seq_gate_test;

    logic clk = 1'b0;
    logic rst_n, ser_bit, ser_stb, ce_in_n, pwr_good, mode_rom;
    logic ce_out_n, unlocked, abort_pulse;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    unlock_seq_gate uut (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_stb(ser_stb),
        .ce_in_n(ce_in_n), .pwr_good(pwr_good), .mode_rom(mode_rom),
        .ce_out_n(ce_out_n), .unlocked(unlocked), .abort_pulse(abort_pulse)
    );

    // Key from its byte list, byte 0 in the low bits (sent LSB first).
    localparam logic [63:0] KEY = {8'h5C, 8'hA3, 8'h3A, 8'hC5, 8'h5C, 8'hA3, 8'h3A, 8'hC5};
    localparam int NVEC = 7;
    localparam logic [63:0] VEC_DATA [NVEC] = '{
        KEY,
        KEY ^ 64'h1,
        KEY ^ (64'h1 << 63),
        KEY ^ (64'h1 << 35),
        64'hC53AA35C_C53AA35C,
        64'h0,
        KEY
    };
    localparam logic VEC_EXP [NVEC] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic strobe(input logic b);
        @(negedge clk); ser_bit = b; ser_stb = 1'b1;
        @(negedge clk); ser_stb = 1'b0;
    endtask

    task automatic send_bits(input logic [63:0] w, input int first, input int count);
        for (int i = first; i < first + count; i++) strobe(w[i]);
    endtask

    task automatic relock();
        @(negedge clk); ce_in_n = 1'b1;
        @(negedge clk); ce_in_n = 1'b0;
    endtask

    initial begin
        #(5 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        rst_n = 1'b0; ser_bit = 1'b0; ser_stb = 1'b0;
        ce_in_n = 1'b1; pwr_good = 1'b1; mode_rom = 1'b0;
        repeat (4) @(negedge clk);
        check("R11", "unlocked in reset", 32'(unlocked), 0);
        check("R11", "abort in reset", 32'(abort_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "unlocked after reset", 32'(unlocked), 0);

        // Vector table: full stream then expected unlock (R1, R3).
        for (int v = 0; v < NVEC; v++) begin
            relock();
            send_bits(VEC_DATA[v], 0, 64);
            check("R1", $sformatf("vector %0d unlock", v), 32'(unlocked), 32'(VEC_EXP[v]));
        end

        // R2: 63 bits do not unlock, the 64th does.
        relock();
        send_bits(KEY, 0, 63);
        check("R2", "after 63 bits", 32'(unlocked), 0);
        strobe(KEY[63]);
        check("R2", "after 64 bits", 32'(unlocked), 1);

        // R5: window lasts 64 strobes.
        send_bits(64'hFFFF_0000_A5A5_1234, 0, 63);
        check("R5", "window after 63", 32'(unlocked), 1);
        strobe(1'b0);
        check("R5", "window after 64", 32'(unlocked), 0);

        // R3: mismatch at bit 40 discards progress.
        relock();
        send_bits(KEY, 0, 40);
        strobe(~KEY[40]);
        send_bits(KEY, 41, 23);
        check("R3", "tail after mismatch", 32'(unlocked), 0);
        relock();
        send_bits(KEY, 0, 64);
        check("R3", "fresh key after mismatch", 32'(unlocked), 1);

        // R4: chip enable release clears progress and closes window.
        @(negedge clk); ce_in_n = 1'b1;
        @(negedge clk);
        check("R4", "window closed by ce", 32'(unlocked), 0);
        send_bits(KEY, 0, 64);
        check("R4", "strobes with ce high", 32'(unlocked), 0);
        ce_in_n = 1'b0;
        send_bits(KEY, 0, 32);
        relock();
        send_bits(KEY, 32, 32);
        check("R4", "split by ce release", 32'(unlocked), 0);

        // R6: pass-through in RAM mode with good power.
        @(negedge clk); ce_in_n = 1'b0; #1;
        check("R6", "ce low passes", 32'(ce_out_n), 0);
        @(negedge clk); ce_in_n = 1'b1; #1;
        check("R6", "ce high passes", 32'(ce_out_n), 1);

        // R7, R9, R10: power fail while unlocked.
        relock();
        send_bits(KEY, 0, 64);
        check("R10", "open before fail", 32'(unlocked), 1);
        @(negedge clk); pwr_good = 1'b0; #1;
        check("R7", "ce forced inactive", 32'(ce_out_n), 1);
        @(negedge clk);
        check("R9", "abort pulse high", 32'(abort_pulse), 1);
        check("R10", "window closed by fail", 32'(unlocked), 0);
        @(negedge clk);
        check("R9", "abort pulse one cycle", 32'(abort_pulse), 0);
        send_bits(KEY, 0, 64);
        check("R10", "key during fail ignored", 32'(unlocked), 0);
        @(negedge clk); pwr_good = 1'b1;
        @(negedge clk);
        check("R10", "still locked on restore", 32'(unlocked), 0);
        send_bits(KEY, 0, 64);
        check("R10", "key after restore", 32'(unlocked), 1);

        // R9: no abort when locked.
        relock();
        @(negedge clk); pwr_good = 1'b0;
        @(negedge clk);
        check("R9", "no abort while locked", 32'(abort_pulse), 0);
        @(negedge clk);
        check("R9", "no abort while locked, next", 32'(abort_pulse), 0);

        // R8: ROM mode passes enable during fail.
        mode_rom = 1'b1;
        @(negedge clk); ce_in_n = 1'b0; #1;
        check("R8", "rom ce low in fail", 32'(ce_out_n), 0);
        @(negedge clk); ce_in_n = 1'b1; #1;
        check("R8", "rom ce high in fail", 32'(ce_out_n), 1);
        @(negedge clk); pwr_good = 1'b1; mode_rom = 1'b0;
        repeat (2) @(negedge clk);

        summary();
    end

endmodule